// File: doc/BRIEF.md
# Boolean Carry-Bit Unit

This block is the single-bit execution unit that sits beside a byte-oriented datapath. It takes one bit-manipulation opcode at a time, together with the value of the addressed bit, that bit's address and the current carry flag. It returns the new carry, a write-back request for the addressed bit, and a branch-taken decision for the conditional bit and carry jumps. The surrounding core decodes bit addresses into RAM or register space, performs the write the unit requests, and computes branch targets. None of that work is inside this block.

The unit is a three-state machine. In ST_IDLE it raises `op_ready` and captures an operation when `op_valid` is high. One-cycle operations take the transition IDLE→RESP. Two-cycle operations take IDLE→HOLD, then HOLD→RESP. ST_RESP lasts exactly one cycle and shows the result with `done`, then takes RESP→IDLE. The two-cycle operations are the AND and OR forms, the carry-to-bit move and every jump. The opcode and operands are sampled only when an operation is accepted. Input changes while the unit is busy have no effect on the result.

The carry flag is also bit 7 of the status word, at bit address D7h. A bit write aimed at that address therefore also sets the carry output in the same response cycle.

Top module: `bit_carry_unit`

## Requirements
- R1: During and right after reset, `op_ready`=1, `done`=0, `bit_we`=0 and `branch_taken`=0.
- R2: An operation is accepted when `op_valid` and `op_ready` are both high. `done` is high for exactly one cycle: one cycle after acceptance for one-cycle operations, and two cycles after for 82h, B0h, 72h, A0h, 92h, 10h, 20h, 30h, 40h and 50h. `op_ready` is low from acceptance until `done` has fallen. While `done` is low, `carry_out` follows `carry_in`, and `bit_we` and `branch_taken` are 0.
- R3: Opcodes C3h, D3h and B3h give a new carry of 0, 1 and the inverse of the sampled carry, respectively. None of them requests a bit write.
- R4: Opcodes C2h, D2h and B2h request a write (`bit_we`=1) of 0, 1 and the inverse of the sampled bit, respectively. The write goes to the captured address on `bit_waddr`. Away from D7h the carry is unchanged.
- R5: Opcodes 82h and 72h give carry AND bit and carry OR bit. Opcodes B0h and A0h give carry AND NOT bit and carry OR NOT bit. None of the four writes the bit.
- R6: Opcode A2h copies the sampled bit into the carry with no write. Opcode 92h writes the sampled carry into the addressed bit.
- R7: Opcode 40h branches when carry=1 and 50h when carry=0. Opcode 20h branches when bit=1 and 30h when bit=0. None of them writes or changes the carry.
- R8: Opcode 10h branches when the sampled bit is 1 and, only in that case, requests a write of 0 to the bit.
- R9: When a bit write targets address D7h, `carry_out` in the `done` cycle equals `bit_wdata`.
- R10: Any other opcode finishes in one cycle with no write, no branch and the carry unchanged.
- R11: Values on the inputs while `op_ready` is low do not change the result of the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered |
| op_code | input | 8 | Operation code |
| op_bit_addr | input | 8 | Address of the operand bit |
| op_bit_val | input | 1 | Current value of the operand bit |
| carry_in | input | 1 | Current carry flag |
| op_ready | output | 1 | Unit idle, can accept |
| done | output | 1 | Result valid this cycle |
| carry_out | output | 1 | New carry when done, else carry_in |
| bit_we | output | 1 | Write request for the operand bit |
| bit_wdata | output | 1 | Value to write |
| bit_waddr | output | 8 | Captured address of the bit to write |
| branch_taken | output | 1 | Jump condition met |

## Verification
Two situations are the hardest to reach from the ports. The first is a write to the status-word carry position, where the bit result and the carry result must agree. The bench reaches it by running every supported opcode, with every combination of bit and carry, at both D7h and an ordinary address. This includes complement-bit and test-and-clear on D7h. The second is an input change during a two-cycle operation. To cover it, the bench drives random opcodes, operands and `op_valid` on every busy cycle and checks that the response still reflects the values captured at acceptance.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_CY_CLR  = 8'hC3;
    localparam logic [OPC_W-1:0] OPC_BT_CLR  = 8'hC2;
    localparam logic [OPC_W-1:0] OPC_CY_SET  = 8'hD3;
    localparam logic [OPC_W-1:0] OPC_BT_SET  = 8'hD2;
    localparam logic [OPC_W-1:0] OPC_CY_INV  = 8'hB3;
    localparam logic [OPC_W-1:0] OPC_BT_INV  = 8'hB2;
    localparam logic [OPC_W-1:0] OPC_AND     = 8'h82;
    localparam logic [OPC_W-1:0] OPC_AND_N   = 8'hB0;
    localparam logic [OPC_W-1:0] OPC_OR      = 8'h72;
    localparam logic [OPC_W-1:0] OPC_OR_N    = 8'hA0;
    localparam logic [OPC_W-1:0] OPC_LD_CY   = 8'hA2;
    localparam logic [OPC_W-1:0] OPC_ST_CY   = 8'h92;
    localparam logic [OPC_W-1:0] OPC_J_TCLR  = 8'h10;
    localparam logic [OPC_W-1:0] OPC_J_BSET  = 8'h20;
    localparam logic [OPC_W-1:0] OPC_J_BCLR  = 8'h30;
    localparam logic [OPC_W-1:0] OPC_J_CSET  = 8'h40;
    localparam logic [OPC_W-1:0] OPC_J_CCLR  = 8'h50;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RESP
    } bp_state_t;

    typedef enum logic [4:0] {
        K_NOP,
        K_CY_CLR, K_CY_SET, K_CY_INV,
        K_BT_CLR, K_BT_SET, K_BT_INV,
        K_AND, K_AND_N, K_OR, K_OR_N,
        K_LD_CY, K_ST_CY,
        K_J_TCLR, K_J_BSET, K_J_BCLR, K_J_CSET, K_J_CCLR
    } bp_kind_t;

    typedef struct packed {
        bp_kind_t kind;
        logic     two_cyc;
    } bp_dec_t;

    typedef struct packed {
        logic carry;
        logic we;
        logic wval;
        logic take;
    } bp_res_t;

endpackage

// File: rtl/bp_decode.sv
module bp_decode
    import bitproc_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    output bp_dec_t          dec
);
    always_comb begin
        dec.kind    = K_NOP;
        dec.two_cyc = 1'b0;
        case (op_code)
            OPC_CY_CLR: dec.kind = K_CY_CLR;
            OPC_CY_SET: dec.kind = K_CY_SET;
            OPC_CY_INV: dec.kind = K_CY_INV;
            OPC_BT_CLR: dec.kind = K_BT_CLR;
            OPC_BT_SET: dec.kind = K_BT_SET;
            OPC_BT_INV: dec.kind = K_BT_INV;
            OPC_LD_CY:  dec.kind = K_LD_CY;
            OPC_AND:    begin dec.kind = K_AND;    dec.two_cyc = 1'b1; end
            OPC_AND_N:  begin dec.kind = K_AND_N;  dec.two_cyc = 1'b1; end
            OPC_OR:     begin dec.kind = K_OR;     dec.two_cyc = 1'b1; end
            OPC_OR_N:   begin dec.kind = K_OR_N;   dec.two_cyc = 1'b1; end
            OPC_ST_CY:  begin dec.kind = K_ST_CY;  dec.two_cyc = 1'b1; end
            OPC_J_TCLR: begin dec.kind = K_J_TCLR; dec.two_cyc = 1'b1; end
            OPC_J_BSET: begin dec.kind = K_J_BSET; dec.two_cyc = 1'b1; end
            OPC_J_BCLR: begin dec.kind = K_J_BCLR; dec.two_cyc = 1'b1; end
            OPC_J_CSET: begin dec.kind = K_J_CSET; dec.two_cyc = 1'b1; end
            OPC_J_CCLR: begin dec.kind = K_J_CCLR; dec.two_cyc = 1'b1; end
            default:    begin dec.kind = K_NOP;    dec.two_cyc = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bp_eval.sv
module bp_eval
    import bitproc_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CARRY_ADDR = 8'hD7
) (
    input  bp_kind_t          kind,
    input  logic              bval,
    input  logic              cval,
    input  logic [ADDR_W-1:0] addr,
    output bp_res_t           res
);
    logic c_n, we_n, wv_n, tk_n;

    always_comb begin
        c_n  = cval;
        we_n = 1'b0;
        wv_n = 1'b0;
        tk_n = 1'b0;
        unique case (kind)
            K_CY_CLR: c_n = 1'b0;
            K_CY_SET: c_n = 1'b1;
            K_CY_INV: c_n = ~cval;
            K_BT_CLR: begin we_n = 1'b1; wv_n = 1'b0;  end
            K_BT_SET: begin we_n = 1'b1; wv_n = 1'b1;  end
            K_BT_INV: begin we_n = 1'b1; wv_n = ~bval; end
            K_AND:    c_n = cval & bval;
            K_AND_N:  c_n = cval & ~bval;
            K_OR:     c_n = cval | bval;
            K_OR_N:   c_n = cval | ~bval;
            K_LD_CY:  c_n = bval;
            K_ST_CY:  begin we_n = 1'b1; wv_n = cval;  end
            K_J_TCLR: begin tk_n = bval; we_n = bval; wv_n = 1'b0; end
            K_J_BSET: tk_n = bval;
            K_J_BCLR: tk_n = ~bval;
            K_J_CSET: tk_n = cval;
            K_J_CCLR: tk_n = ~cval;
            default:  c_n = cval;
        endcase
        // a write landing on the status-word carry position is the carry
        if (we_n && (addr == CARRY_ADDR))
            c_n = wv_n;
        res.carry = c_n;
        res.we    = we_n;
        res.wval  = wv_n;
        res.take  = tk_n;
    end

    // carry-only operations never request a bit write (R3)
    always_comb begin
        if (kind == K_CY_CLR || kind == K_CY_SET || kind == K_CY_INV)
            p_cy_ops_no_write_r3: assert (!we_n);
    end

    // inverted-source forms only read the bit (R5)
    always_comb begin
        if (kind == K_AND_N || kind == K_OR_N)
            p_inv_src_no_write_r5: assert (!we_n && !tk_n);
    end
endmodule

// File: rtl/bit_carry_unit.sv
module bit_carry_unit
    import bitproc_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CARRY_ADDR = 8'hD7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [ADDR_W-1:0] op_bit_addr,
    input  logic              op_bit_val,
    input  logic              carry_in,
    output logic              op_ready,
    output logic              done,
    output logic              carry_out,
    output logic              bit_we,
    output logic              bit_wdata,
    output logic [ADDR_W-1:0] bit_waddr,
    output logic              branch_taken
);
    bp_state_t         state_q, state_d;
    bp_dec_t           dec;
    bp_res_t           res_now, res_q;
    bp_kind_t          kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    bp_decode u_dec (
        .op_code (op_code),
        .dec     (dec)
    );

    bp_eval #(
        .ADDR_W     (ADDR_W),
        .CARRY_ADDR (CARRY_ADDR)
    ) u_eval (
        .kind (dec.kind),
        .bval (op_bit_val),
        .cval (carry_in),
        .addr (op_bit_addr),
        .res  (res_now)
    );

    assign accept = (state_q == ST_IDLE) && op_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = dec.two_cyc ? ST_HOLD : ST_RESP;
            ST_HOLD: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
            addr_q  <= '0;
            kind_q  <= K_NOP;
        end else begin
            state_q <= state_d;
            if (accept) begin
                res_q  <= res_now;
                addr_q <= op_bit_addr;
                kind_q <= dec.kind;
            end
        end
    end

    always_comb begin
        op_ready     = (state_q == ST_IDLE);
        done         = (state_q == ST_RESP);
        carry_out    = done ? res_q.carry : carry_in;
        bit_we       = done & res_q.we;
        bit_wdata    = res_q.wval;
        bit_waddr    = addr_q;
        branch_taken = done & res_q.take;
    end

    p_single_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> op_ready);
    p_hold_then_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> done);
    p_fast_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid && !dec.two_cyc) |=> done);
    p_tclr_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == K_J_TCLR && branch_taken) |-> (bit_we && !bit_wdata));
    p_tclr_not_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == K_J_TCLR && !branch_taken) |-> !bit_we);
    p_carry_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bit_we && bit_waddr == CARRY_ADDR) |-> (carry_out == bit_wdata));
endmodule

// File: tb/sim_bit_carry_unit.sv
module sim_bit_carry_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] op_bit_addr = 8'h00;
    logic       op_bit_val = 1'b0;
    logic       carry_in = 1'b0;
    logic       op_ready, done, carry_out, bit_we, bit_wdata, branch_taken;
    logic [7:0] bit_waddr;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bit_carry_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_bit_addr(op_bit_addr), .op_bit_val(op_bit_val), .carry_in(carry_in),
        .op_ready(op_ready), .done(done), .carry_out(carry_out), .bit_we(bit_we),
        .bit_wdata(bit_wdata), .bit_waddr(bit_waddr), .branch_taken(branch_taken)
    );

    logic [7:0] op_list [20] = '{8'hC3, 8'hD3, 8'hB3, 8'hC2, 8'hD2, 8'hB2,
                                 8'h82, 8'h72, 8'hB0, 8'hA0, 8'hA2, 8'h92,
                                 8'h40, 8'h50, 8'h20, 8'h30, 8'h10,
                                 8'h00, 8'hA5, 8'hFF};

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'hC3, 8'hD3, 8'hB3: return "R3";
            8'hC2, 8'hD2, 8'hB2: return "R4";
            8'h82, 8'h72, 8'hB0, 8'hA0: return "R5";
            8'hA2, 8'h92: return "R6";
            8'h40, 8'h50, 8'h20, 8'h30: return "R7";
            8'h10: return "R8";
            default: return "R10";
        endcase
    endfunction

    // reference: returns {carry, we, wval, take}; cycles via output
    function automatic logic [3:0] ref_of(input logic [7:0] op, input logic b, input logic c,
                                          input logic [7:0] a, output int cyc);
        logic nc, we, wv, tk;
        nc = c; we = 0; wv = 0; tk = 0; cyc = 1;
        if (op == 8'hC3) nc = 0;
        else if (op == 8'hD3) nc = 1;
        else if (op == 8'hB3) nc = !c;
        else if (op == 8'hC2) begin we = 1; wv = 0; end
        else if (op == 8'hD2) begin we = 1; wv = 1; end
        else if (op == 8'hB2) begin we = 1; wv = !b; end
        else if (op == 8'hA2) nc = b;
        else if (op == 8'h82) begin nc = c && b;  cyc = 2; end
        else if (op == 8'h72) begin nc = c || b;  cyc = 2; end
        else if (op == 8'hB0) begin nc = c && !b; cyc = 2; end
        else if (op == 8'hA0) begin nc = c || !b; cyc = 2; end
        else if (op == 8'h92) begin we = 1; wv = c; cyc = 2; end
        else if (op == 8'h40) begin tk = c;  cyc = 2; end
        else if (op == 8'h50) begin tk = !c; cyc = 2; end
        else if (op == 8'h20) begin tk = b;  cyc = 2; end
        else if (op == 8'h30) begin tk = !b; cyc = 2; end
        else if (op == 8'h10) begin tk = b; we = b; wv = 0; cyc = 2; end
        if (we && a == 8'hD7) nc = wv;
        return {nc, we, wv, tk};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired, run hung");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int         m_state;
        logic [3:0] m_res;
        logic [7:0] m_addr;
        string      m_tag;
        int         item;
        int         n_items;
        int         idle_cnt;
        int         cyc;
        logic       e_done;
        n_items  = 160 + 300;
        m_state  = 0;
        m_res    = '0;
        m_addr   = '0;
        m_tag    = "R2";
        item     = 0;
        idle_cnt = 0;

        repeat (3) @(negedge clk);
        chk("R1", "op_ready in reset", {7'd0, op_ready}, 8'd1);
        chk("R1", "done in reset", {7'd0, done}, 8'd0);
        chk("R1", "bit_we in reset", {7'd0, bit_we}, 8'd0);
        chk("R1", "branch in reset", {7'd0, branch_taken}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "op_ready after reset", {7'd0, op_ready}, 8'd1);
        chk("R1", "done after reset", {7'd0, done}, 8'd0);

        for (int t = 0; t < 6000 && item < n_items; t++) begin
            // compare outputs against the model
            e_done = (m_state == 2);
            chk("R2", "op_ready", {7'd0, op_ready}, {7'd0, m_state == 0});
            chk("R2", "done", {7'd0, done}, {7'd0, e_done});
            if (e_done) begin
                chk(m_res[2] && m_addr == 8'hD7 ? "R9" : m_tag, "carry_out", {7'd0, carry_out}, {7'd0, m_res[3]});
                chk(m_tag, "bit_we", {7'd0, bit_we}, {7'd0, m_res[2]});
                chk(m_tag, "branch", {7'd0, branch_taken}, {7'd0, m_res[0]});
                if (m_res[2]) begin
                    chk(m_tag, "bit_wdata", {7'd0, bit_wdata}, {7'd0, m_res[1]});
                    chk(m_tag, "bit_waddr", bit_waddr, m_addr);
                end
            end else begin
                chk("R2", "carry passthrough", {7'd0, carry_out}, {7'd0, carry_in});
                chk("R2", "bit_we idle", {7'd0, bit_we}, 8'd0);
                chk("R2", "branch idle", {7'd0, branch_taken}, 8'd0);
            end

            // drive next inputs
            if (m_state == 0) begin
                idle_cnt++;
                if (idle_cnt % 5 == 0) begin
                    op_valid = 1'b0;
                    op_code  = 8'($urandom);
                end else if (item < 160) begin
                    op_valid    = 1'b1;
                    op_code     = op_list[item / 8];
                    op_bit_val  = item[0];
                    carry_in    = item[1];
                    op_bit_addr = item[2] ? 8'hD7 : 8'h2F;
                end else begin
                    op_valid    = 1'b1;
                    op_code     = op_list[$urandom_range(19, 0)];
                    op_bit_val  = 1'($urandom);
                    carry_in    = 1'($urandom);
                    op_bit_addr = ($urandom_range(3, 0) == 0) ? 8'hD7 : 8'($urandom);
                end
            end else begin
                // R11: noise while busy must not disturb the operation in flight
                op_valid    = 1'($urandom);
                op_code     = op_list[$urandom_range(19, 0)];
                op_bit_val  = 1'($urandom);
                carry_in    = 1'($urandom);
                op_bit_addr = 8'($urandom);
            end

            // advance model across the coming edge
            case (m_state)
                0: if (op_valid) begin
                       m_res   = ref_of(op_code, op_bit_val, carry_in, op_bit_addr, cyc);
                       m_addr  = op_bit_addr;
                       m_tag   = tag_of(op_code);
                       m_state = (cyc == 2) ? 1 : 2;
                       item++;
                   end
                1: m_state = 2;
                default: m_state = 0;
            endcase
            @(negedge clk);
        end
        chk("R2", "all operations issued", (item >= n_items) ? 8'd1 : 8'd0, 8'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule